// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block turns the interrupt requests of a 16550-style serial controller into the byte that software reads from the interrupt identification register, and into the one interrupt line that goes to the host. It takes five request sources: a line-status error, received data at the trigger level, a character timeout, an empty transmit holding register, and a modem-status change. It also takes the four per-source enable bits and a FIFO-mode flag. It reports the highest-priority enabled request that is pending. Line-status, timeout and modem events arrive as one-cycle pulses. The block holds each one until its clearing register access. Received-data-available is a level that the receive FIFO drives.

The transmit-empty request belongs to a small state machine with three states. FULL means the holding register is occupied and nothing is requested. ARMED means the register is empty and the request is pending. SERVED means the register is empty and software has seen the request. The transitions are:

- FULL to ARMED when the holding-empty input rises and the same cycle carries no THR write.
- ARMED to SERVED when an identification-register read returns the transmit-empty code.
- SERVED to ARMED when the transmit-empty enable rises.
- ARMED or SERVED to FULL on a THR write, or when holding-empty goes low.

Reset enters SERVED.

Top module: `uart_irq_ident`

## Requirements
- R1: During and after reset, with no request pending, `iir_value` reads 0x01 and `irq` is 0.
- R2: Bits 3:0 of `iir_value` hold the code of the reported source: 0x6 for line status, 0x4 for received data, 0xC for character timeout, 0x2 for transmit empty, 0x0 for modem status, and 0x1 when nothing is pending. Bit 0 is 1 only in the last case.
- R3: The priority order is line status first, then received data, then character timeout, then transmit empty, then modem status. Received data wins over a timeout that is pending at the same time.
- R4: `ier_en` bit 0 enables received data and timeout, bit 1 enables transmit empty, bit 2 enables line status, and bit 3 enables modem status. An event that arrives while its source is disabled stays latched, and it is reported once the bit is set.
- R5: When the transmit-empty enable rises while the holding register is empty, the transmit-empty request is raised at once.
- R6: An identification-register read clears the transmit-empty request only when the value returned on that read carries code 0x2. A read that returns any other code leaves it pending.
- R7: A THR write clears the transmit-empty request. The request re-arms on the next rising edge of `thr_empty`.
- R8: An LSR read clears a latched line-status event, an RBR read clears a latched timeout, and an MSR read clears a latched modem event. An event that arrives in the same cycle as its clearing read stays pending.
- R9: Bits 7:6 of `iir_value` read 11 while `fifo_on` is 1 and 00 otherwise. Bits 5:4 are always 0.
- R10: `iir_value` and `irq` are registered. They reflect the request state one cycle later, and `irq` is the inverse of `iir_value` bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_evt | input | 1 | One-cycle pulse for a receive line error |
| rx_avail | input | 1 | Level: receive data at the trigger level |
| tmo_evt | input | 1 | One-cycle pulse for a character timeout |
| thr_empty | input | 1 | Level: transmit holding register empty |
| modem_evt | input | 1 | One-cycle pulse for a modem input change |
| ier_en | input | 4 | Per-source interrupt enables |
| fifo_on | input | 1 | FIFO mode active |
| rd_iir | input | 1 | Strobe: identification register read |
| rd_lsr | input | 1 | Strobe: line status register read |
| rd_rbr | input | 1 | Strobe: receive buffer read |
| wr_thr | input | 1 | Strobe: transmit holding register write |
| rd_msr | input | 1 | Strobe: modem status register read |
| iir_value | output | 8 | Identification register contents |
| irq | output | 1 | Interrupt request to the host |

## Verification
The bench stacks all five sources at once and then removes them one by one. A design with a misordered priority chain would therefore show the wrong code at some step, for example timeout ahead of received data, or modem ahead of transmit empty. An identification-register read is issued while line status is on top, so a design that clears transmit-empty on every read would skip code 0x2 when line status and received data are later cleared. Other directed tests check that an event arriving with its enable off is latched and not lost, that an event beats its own clearing read in the same cycle, and that a THR write suppresses the request until the holding-empty input rises again. A design that re-armed on the level instead of the edge would re-raise the request at once after the write.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [1:0] {
        THRE_FULL   = 2'd0,
        THRE_ARMED  = 2'd1,
        THRE_SERVED = 2'd2
    } thre_state_e;

    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_NONE    = 4'h1;
    localparam logic [CODE_W-1:0] CODE_LINE    = 4'h6;
    localparam logic [CODE_W-1:0] CODE_RXDATA  = 4'h4;
    localparam logic [CODE_W-1:0] CODE_TIMEOUT = 4'hC;
    localparam logic [CODE_W-1:0] CODE_THRE    = 4'h2;
    localparam logic [CODE_W-1:0] CODE_MODEM   = 4'h0;

    localparam int EN_W     = 4;
    localparam int EN_RX    = 0;
    localparam int EN_THRE  = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

endpackage

// File: rtl/uart_irq_evt_latch.sv
module uart_irq_evt_latch #(
    parameter int NUM_EVT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] set_i,
    input  logic [NUM_EVT-1:0] clr_i,
    output logic [NUM_EVT-1:0] pend_o
);

    // one sticky flag per event source; a new event beats its clear
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_o[g] <= 1'b0;
            end else if (set_i[g]) begin
                pend_o[g] <= 1'b1;
            end else if (clr_i[g]) begin
                pend_o[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_irq_thre_fsm.sv
module uart_irq_thre_fsm
    import uart_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        thr_empty_i,
    input  logic        thre_en_i,
    input  logic        wr_thr_i,
    input  logic        ack_i,
    output thre_state_e state_o,
    output logic        req_o
);

    thre_state_e state_q, state_d;
    logic        empty_prev_q;
    logic        en_prev_q;
    logic        empty_rise;
    logic        en_rise;

    assign empty_rise = thr_empty_i && !empty_prev_q;
    assign en_rise    = thre_en_i && !en_prev_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            THRE_FULL: begin
                if (empty_rise && !wr_thr_i) state_d = THRE_ARMED;
            end
            THRE_ARMED: begin
                if (wr_thr_i || !thr_empty_i) state_d = THRE_FULL;
                else if (ack_i)               state_d = THRE_SERVED;
            end
            THRE_SERVED: begin
                if (wr_thr_i || !thr_empty_i) state_d = THRE_FULL;
                else if (en_rise)             state_d = THRE_ARMED;
            end
            default: state_d = THRE_FULL;
        endcase
    end

    // state register and edge-detect history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= THRE_SERVED;
            empty_prev_q <= 1'b1;
            en_prev_q    <= 1'b0;
        end else begin
            state_q      <= state_d;
            empty_prev_q <= thr_empty_i;
            en_prev_q    <= thre_en_i;
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
        req_o   = (state_q == THRE_ARMED);
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic              line_i,
    input  logic              rx_i,
    input  logic              tmo_i,
    input  logic              thre_i,
    input  logic              modem_i,
    input  logic [EN_W-1:0]   ier_i,
    output logic [CODE_W-1:0] code_o
);

    always_comb begin
        if (line_i && ier_i[EN_LINE]) begin
            code_o = CODE_LINE;
        end else if (rx_i && ier_i[EN_RX]) begin
            code_o = CODE_RXDATA;
        end else if (tmo_i && ier_i[EN_RX]) begin
            code_o = CODE_TIMEOUT;
        end else if (thre_i && ier_i[EN_THRE]) begin
            code_o = CODE_THRE;
        end else if (modem_i && ier_i[EN_MODEM]) begin
            code_o = CODE_MODEM;
        end else begin
            code_o = CODE_NONE;
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int IIR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_evt,
    input  logic             rx_avail,
    input  logic             tmo_evt,
    input  logic             thr_empty,
    input  logic             modem_evt,
    input  logic [EN_W-1:0]  ier_en,
    input  logic             fifo_on,
    input  logic             rd_iir,
    input  logic             rd_lsr,
    input  logic             rd_rbr,
    input  logic             wr_thr,
    input  logic             rd_msr,
    output logic [IIR_W-1:0] iir_value,
    output logic             irq
);

    localparam int NUM_EVT  = 3;
    localparam int IX_LINE  = 0;
    localparam int IX_TMO   = 1;
    localparam int IX_MODEM = 2;
    localparam int MARK_W   = 2;
    localparam int GAP_W    = IIR_W - CODE_W - MARK_W;

    logic [NUM_EVT-1:0] evt_set;
    logic [NUM_EVT-1:0] evt_clr;
    logic [NUM_EVT-1:0] evt_pend;
    logic               line_pend;
    logic               thre_req;
    logic               thre_ack;
    thre_state_e        thre_state;
    logic [CODE_W-1:0]  code_next;
    logic [IIR_W-1:0]   iir_q;
    logic               irq_q;

    assign evt_set[IX_LINE]  = line_evt;
    assign evt_set[IX_TMO]   = tmo_evt;
    assign evt_set[IX_MODEM] = modem_evt;
    assign evt_clr[IX_LINE]  = rd_lsr;
    assign evt_clr[IX_TMO]   = rd_rbr;
    assign evt_clr[IX_MODEM] = rd_msr;
    assign line_pend         = evt_pend[IX_LINE];

    uart_irq_evt_latch #(
        .NUM_EVT (NUM_EVT)
    ) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_set),
        .clr_i  (evt_clr),
        .pend_o (evt_pend)
    );

    // the read returns iir_q, so the acknowledge compares against it
    assign thre_ack = rd_iir && (iir_q[CODE_W-1:0] == CODE_THRE);

    uart_irq_thre_fsm u_thre (
        .clk         (clk),
        .rst_n       (rst_n),
        .thr_empty_i (thr_empty),
        .thre_en_i   (ier_en[EN_THRE]),
        .wr_thr_i    (wr_thr),
        .ack_i       (thre_ack),
        .state_o     (thre_state),
        .req_o       (thre_req)
    );

    uart_irq_prio u_prio (
        .line_i  (evt_pend[IX_LINE]),
        .rx_i    (rx_avail),
        .tmo_i   (evt_pend[IX_TMO]),
        .thre_i  (thre_req),
        .modem_i (evt_pend[IX_MODEM]),
        .ier_i   (ier_en),
        .code_o  (code_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iir_q <= {{(IIR_W-CODE_W){1'b0}}, CODE_NONE};
            irq_q <= 1'b0;
        end else begin
            iir_q <= {{MARK_W{fifo_on}}, {GAP_W{1'b0}}, code_next};
            irq_q <= ~code_next[0];
        end
    end

    assign iir_value = iir_q;
    assign irq       = irq_q;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
    import uart_irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [7:0]      iir_value,
    input logic            fifo_on,
    input logic [EN_W-1:0] ier_en,
    input logic            line_pend,
    input logic            line_evt,
    input logic            rd_lsr,
    input logic            rd_iir,
    input logic            wr_thr,
    input logic            thr_empty,
    input thre_state_e     thre_state
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_line_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(line_pend && ier_en[EN_LINE]) |-> iir_value[3:0] == CODE_LINE);

    p_thre_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_iir && iir_value[3:0] == CODE_THRE && thre_state == THRE_ARMED
        && !wr_thr && thr_empty |=> thre_state == THRE_SERVED);

    p_wr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_thr |=> thre_state == THRE_FULL);

    p_lsr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lsr && !line_evt |=> !line_pend);

    p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_evt |=> line_pend);

    p_fifo_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> iir_value[7:6] == {2{$past(fifo_on)}} && iir_value[5:4] == 2'b00);

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iir_value  (iir_value),
    .fifo_on    (fifo_on),
    .ier_en     (ier_en),
    .line_pend  (line_pend),
    .line_evt   (line_evt),
    .rd_lsr     (rd_lsr),
    .rd_iir     (rd_iir),
    .wr_thr     (wr_thr),
    .thr_empty  (thr_empty),
    .thre_state (thre_state)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;

    localparam time CLK_PERIOD = 10ns;

    // strobe mask bits used by pulse()
    localparam int B_RD_IIR = 0, B_RD_LSR = 1, B_RD_RBR = 2, B_WR_THR = 3;
    localparam int B_RD_MSR = 4, B_LINE = 5, B_TMO = 6, B_MODEM = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_evt = 0, rx_avail = 0, tmo_evt = 0, thr_empty = 1, modem_evt = 0;
    logic [3:0] ier_en = 4'h0;
    logic       fifo_on = 0;
    logic       rd_iir = 0, rd_lsr = 0, rd_rbr = 0, wr_thr = 0, rd_msr = 0;
    logic [7:0] iir_value;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ident uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_evt  (line_evt),
        .rx_avail  (rx_avail),
        .tmo_evt   (tmo_evt),
        .thr_empty (thr_empty),
        .modem_evt (modem_evt),
        .ier_en    (ier_en),
        .fifo_on   (fifo_on),
        .rd_iir    (rd_iir),
        .rd_lsr    (rd_lsr),
        .rd_rbr    (rd_rbr),
        .wr_thr    (wr_thr),
        .rd_msr    (rd_msr),
        .iir_value (iir_value),
        .irq       (irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        tick();
        tick();
    endtask

    task automatic check(input string tag, input logic [7:0] exp_iir, input logic exp_irq);
        n_checks++;
        if (iir_value !== exp_iir || irq !== exp_irq) begin
            n_fails++;
            $display("FAIL %s: iir=%02h irq=%0b expected iir=%02h irq=%0b",
                     tag, iir_value, irq, exp_iir, exp_irq);
        end
    endtask

    task automatic pulse(input logic [7:0] m);
        rd_iir    = m[B_RD_IIR];
        rd_lsr    = m[B_RD_LSR];
        rd_rbr    = m[B_RD_RBR];
        wr_thr    = m[B_WR_THR];
        rd_msr    = m[B_RD_MSR];
        line_evt  = m[B_LINE];
        tmo_evt   = m[B_TMO];
        modem_evt = m[B_MODEM];
        tick();
        {rd_iir, rd_lsr, rd_rbr, wr_thr, rd_msr, line_evt, tmo_evt, modem_evt} = '0;
        tick();
    endtask

    task automatic t_reset();
        check("R1 in reset", 8'h01, 1'b0);
        rst_n = 1'b1;
        settle();
        check("R1 after reset", 8'h01, 1'b0);
    endtask

    task automatic t_thre();
        ier_en = 4'b0010; settle();
        check("R5 enable while empty", 8'h02, 1'b1);
        pulse(8'h01 << B_RD_IIR);
        check("R6 iir read clears thre", 8'h01, 1'b0);
        ier_en = 4'b0000; settle();
        ier_en = 4'b0010; settle();
        check("R5 re-enable raises thre", 8'h02, 1'b1);
        wr_thr = 1'b1; tick();
        wr_thr = 1'b0; thr_empty = 1'b0; settle();
        check("R7 thr write clears", 8'h01, 1'b0);
        tick();
        check("R7 no rearm while full", 8'h01, 1'b0);
        thr_empty = 1'b1; settle();
        check("R7 rearm on empty edge", 8'h02, 1'b1);
    endtask

    task automatic t_priority();
        ier_en = 4'hF; settle();
        pulse(8'h01 << B_MODEM);
        check("R3 thre over modem", 8'h02, 1'b1);
        pulse(8'h01 << B_TMO);
        check("R3 timeout over thre", 8'h0C, 1'b1);
        rx_avail = 1'b1; settle();
        check("R3 rxdata over timeout", 8'h04, 1'b1);
        pulse(8'h01 << B_LINE);
        check("R2 line status top", 8'h06, 1'b1);
        pulse(8'h01 << B_RD_IIR);
        check("R6 read of other code keeps thre", 8'h06, 1'b1);
        pulse(8'h01 << B_RD_LSR);
        check("R8 lsr read clears line", 8'h04, 1'b1);
        rx_avail = 1'b0; settle();
        check("R3 timeout after rxdata drops", 8'h0C, 1'b1);
        pulse(8'h01 << B_RD_RBR);
        check("R6 thre survived earlier read", 8'h02, 1'b1);
        pulse(8'h01 << B_RD_IIR);
        check("R2 modem code zero", 8'h00, 1'b1);
        pulse(8'h01 << B_RD_MSR);
        check("R8 msr read clears modem", 8'h01, 1'b0);
    endtask

    task automatic t_enables();
        ier_en = 4'h0; settle();
        pulse(8'h01 << B_LINE);
        check("R4 disabled line hidden", 8'h01, 1'b0);
        ier_en = 4'b0100; settle();
        check("R4 latched line shown", 8'h06, 1'b1);
        pulse(8'h01 << B_RD_LSR);
        check("R8 line cleared", 8'h01, 1'b0);
        pulse(8'h01 << B_MODEM);
        check("R4 modem disabled", 8'h01, 1'b0);
        ier_en = 4'b1100; settle();
        check("R4 modem enabled", 8'h00, 1'b1);
        pulse(8'h01 << B_RD_MSR);
        check("R10 irq low when none", 8'h01, 1'b0);
    endtask

    task automatic t_same_cycle();
        pulse((8'h01 << B_LINE) | (8'h01 << B_RD_LSR));
        check("R8 event beats clear", 8'h06, 1'b1);
        pulse(8'h01 << B_RD_LSR);
        check("R8 later clear", 8'h01, 1'b0);
    endtask

    task automatic t_fifo();
        fifo_on = 1'b1; settle();
        check("R9 fifo mark none", 8'hC1, 1'b0);
        pulse(8'h01 << B_LINE);
        check("R9 fifo mark line", 8'hC6, 1'b1);
        fifo_on = 1'b0; tick();
        check("R9 mark off", 8'h06, 1'b1);
        pulse(8'h01 << B_RD_LSR);
        check("R10 final idle", 8'h01, 1'b0);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        t_thre();
        t_priority();
        t_enables();
        t_same_cycle();
        t_fifo();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: iir=%02h irq=%0b expected run to end", iir_value, irq);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule